// File: doc/BRIEF.md
# Head-Tail Bundle Instruction Extractor

This block takes one 128-bit instruction bundle and splits it into aligned instruction pieces. Each bundle carries fixed-size heads packed forward from just below a small index field, and variable-size tails packed backward from the bundle's last bit. Every head's opcode is decoded at the same time to find its tail size. A short prefix-sum chain of tail sizes then gives the unit offset of each tail, so the only serial path in the block is that adder chain. No scan walks instruction boundaries one at a time.

Each result is registered once. One cycle after a valid bundle, the block presents, for each of its eight slots, a valid flag, the 10-bit head, the tail bits right-aligned and the tail size in units. It also presents the instruction count and a flag for bundles whose heads and tails do not fit. A front end uses it to feed several instructions per cycle to later decode stages.

Top module: `htx_bundle_extract`

## Requirements
- R1: Bits [127:125] hold the index of the last instruction, and o_count is that index plus one. Bits [124:0] are twenty-five 5-bit units. Head s is bits [124-10s -: 10] and appears on o_head[10s +: 10] when its slot is valid.
- R2: A head's opcode is its upper 5 bits. Its tail size in units is (opcode mod 6) + 1, so it lies in 1..6, and it appears on o_tlen[3s +: 3].
- R3: Tail 0 ends at bit 0, and each later tail sits directly before the previous one. With S the sum of the sizes of tails 0..s-1, tail s is bits [5S +: 5*size]. It is placed right-aligned on o_tail[30s +: 30], with all bits above it zero.
- R4: Slots with an index above the last-instruction index have o_slot_vld low and all-zero head, tail and size outputs.
- R5: If 2*count plus the summed tail sizes exceeds 25 units, the block raises o_overflow, clears every slot valid flag and zeroes every slot output. o_count still reports the count.
- R6: A bundle that uses exactly 25 units is not an overflow and is extracted normally.
- R7: o_valid is i_valid delayed by one clock. The results for a bundle appear in the same cycle as its o_valid.
- R8: When i_valid is low, every output other than o_valid keeps its value from the last accepted bundle.
- R9: While reset is asserted and after its release, before any bundle arrives, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Bundle strobe |
| i_bundle | input | 128 | Bundle: last-index field and 25 units |
| o_valid | output | 1 | Results valid, one cycle after the strobe |
| o_count | output | 4 | Number of instructions in the bundle |
| o_overflow | output | 1 | Bundle needs more than 25 units |
| o_slot_vld | output | 8 | Per-slot valid flags |
| o_head | output | 80 | Eight 10-bit heads |
| o_tail | output | 240 | Eight right-aligned 30-bit tails |
| o_tlen | output | 24 | Eight 3-bit tail sizes in units |

## Verification
The hardest cases to reach are the ones on the unit budget. A bundle that fills exactly 25 units must pass, and one that needs 26 must be flagged. Random bundles rarely land there, because most full bundles overshoot by far. The bench therefore builds bundles from chosen opcodes: eight instructions with one-unit tails, then one tail grown to two units (exactly full), then to three units (one over). Random bundles with random strobe gaps cover tail offsets and the hold behaviour.

// File: rtl/htx_pkg.sv
package htx_pkg;
   // Tail size in units carried by a primary opcode: one of 1..max_units.
   function automatic int unsigned htx_tail_units(input int unsigned opc,
                                                  input int unsigned max_units);
      return (opc % max_units) + 1;
   endfunction
endpackage

// File: rtl/htx_len_dec.sv
module htx_len_dec #(
   parameter int OPC_W    = 5,
   parameter int MAX_TAIL = 6,
   parameter int LEN_W    = 3
) (
   input  logic [OPC_W-1:0] i_opc,
   output logic [LEN_W-1:0] o_len
);
   import htx_pkg::*;
   always_comb begin
      o_len = LEN_W'(htx_tail_units(int'(i_opc), MAX_TAIL));
   end
endmodule

// File: rtl/htx_prefix.sv
module htx_prefix #(
   parameter int SLOTS = 8,
   parameter int LEN_W = 3,
   parameter int SUM_W = 6
) (
   input  logic [SLOTS*LEN_W-1:0] i_len,
   output logic [SLOTS*SUM_W-1:0] o_start,
   output logic [SUM_W-1:0]       o_total
);
   logic [SUM_W-1:0] acc [SLOTS+1];

   assign acc[0] = '0;
   for (genvar s = 0; s < SLOTS; s++) begin : g_chain
      assign acc[s+1] = acc[s] + SUM_W'(i_len[s*LEN_W +: LEN_W]);
      assign o_start[s*SUM_W +: SUM_W] = acc[s];
   end
   assign o_total = acc[SLOTS];
endmodule

// File: rtl/htx_tail_pick.sv
module htx_tail_pick #(
   parameter int PAY_W    = 125,
   parameter int UNIT_W   = 5,
   parameter int MAX_TAIL = 6,
   parameter int LEN_W    = 3,
   parameter int SUM_W    = 6
) (
   input  logic [PAY_W-1:0]           i_payload,
   input  logic [SUM_W-1:0]           i_start,
   input  logic [LEN_W-1:0]           i_len,
   output logic [UNIT_W*MAX_TAIL-1:0] o_tail
);
   localparam int TAIL_W = UNIT_W * MAX_TAIL;

   logic [PAY_W-1:0]  shifted;
   logic [TAIL_W-1:0] keep;

   always_comb begin
      shifted = i_payload >> (UNIT_W * int'(i_start));
      for (int u = 0; u < MAX_TAIL; u++) begin
         keep[u*UNIT_W +: UNIT_W] = (u < int'(i_len)) ? '1 : '0;
      end
      o_tail = shifted[TAIL_W-1:0] & keep;
   end
endmodule

// File: rtl/htx_bundle_extract.sv
module htx_bundle_extract #(
   parameter int UNIT_W     = 5,
   parameter int N_UNITS    = 25,
   parameter int IDX_W      = 3,
   parameter int HEAD_UNITS = 2,
   parameter int OPC_W      = 5,
   parameter int MAX_TAIL   = 6
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          i_valid,
   input  logic [IDX_W+UNIT_W*N_UNITS-1:0]               i_bundle,
   output logic                                          o_valid,
   output logic [IDX_W:0]                                o_count,
   output logic                                          o_overflow,
   output logic [(1<<IDX_W)-1:0]                         o_slot_vld,
   output logic [(1<<IDX_W)*HEAD_UNITS*UNIT_W-1:0]       o_head,
   output logic [(1<<IDX_W)*MAX_TAIL*UNIT_W-1:0]         o_tail,
   output logic [(1<<IDX_W)*$clog2(MAX_TAIL+1)-1:0]      o_tlen
);
   localparam int PAY_W    = UNIT_W * N_UNITS;
   localparam int BUNDLE_W = IDX_W + PAY_W;
   localparam int SLOTS    = 1 << IDX_W;
   localparam int HEAD_W   = HEAD_UNITS * UNIT_W;
   localparam int TAIL_W   = MAX_TAIL * UNIT_W;
   localparam int LEN_W    = $clog2(MAX_TAIL + 1);
   localparam int SUM_W    = $clog2(SLOTS * MAX_TAIL + 1);
   localparam int USE_W    = $clog2(SLOTS * (HEAD_UNITS + MAX_TAIL) + 1);

   // elaboration-time parameter checks
   if (SLOTS * HEAD_W > PAY_W) begin : g_bad_heads
      $error("htx_bundle_extract: heads of all slots exceed the payload");
   end
   if (OPC_W > HEAD_W) begin : g_bad_opc
      $error("htx_bundle_extract: opcode wider than head");
   end
   if (MAX_TAIL < 1) begin : g_bad_tail
      $error("htx_bundle_extract: MAX_TAIL must be at least 1");
   end

   logic [IDX_W-1:0]        last_idx;
   logic [IDX_W:0]          count;
   logic [PAY_W-1:0]        payload;
   logic [SLOTS-1:0]        active;
   logic [SLOTS*HEAD_W-1:0] head_raw;
   logic [SLOTS*LEN_W-1:0]  len_raw;
   logic [SLOTS*LEN_W-1:0]  len_act;
   logic [SLOTS*SUM_W-1:0]  start;
   logic [SUM_W-1:0]        tail_total;
   logic [SLOTS*TAIL_W-1:0] tail_raw;
   logic [USE_W-1:0]        used;
   logic                    overflow;

   assign last_idx = i_bundle[BUNDLE_W-1 -: IDX_W];
   assign payload  = i_bundle[PAY_W-1:0];
   assign count    = {1'b0, last_idx} + 1'b1;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign active[s] = (s <= int'(last_idx));
      assign head_raw[s*HEAD_W +: HEAD_W] = payload[PAY_W-1-s*HEAD_W -: HEAD_W];

      htx_len_dec #(.OPC_W(OPC_W), .MAX_TAIL(MAX_TAIL), .LEN_W(LEN_W)) u_dec (
         .i_opc (head_raw[s*HEAD_W+HEAD_W-1 -: OPC_W]),
         .o_len (len_raw[s*LEN_W +: LEN_W])
      );

      assign len_act[s*LEN_W +: LEN_W] = active[s] ? len_raw[s*LEN_W +: LEN_W] : '0;

      htx_tail_pick #(.PAY_W(PAY_W), .UNIT_W(UNIT_W), .MAX_TAIL(MAX_TAIL),
                      .LEN_W(LEN_W), .SUM_W(SUM_W)) u_pick (
         .i_payload (payload),
         .i_start   (start[s*SUM_W +: SUM_W]),
         .i_len     (len_act[s*LEN_W +: LEN_W]),
         .o_tail    (tail_raw[s*TAIL_W +: TAIL_W])
      );
   end

   htx_prefix #(.SLOTS(SLOTS), .LEN_W(LEN_W), .SUM_W(SUM_W)) u_prefix (
      .i_len   (len_act),
      .o_start (start),
      .o_total (tail_total)
   );

   assign used     = USE_W'(int'(count) * HEAD_UNITS) + USE_W'(tail_total);
   assign overflow = (int'(used) > N_UNITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid    <= 1'b0;
         o_count    <= '0;
         o_overflow <= 1'b0;
         o_slot_vld <= '0;
         o_head     <= '0;
         o_tail     <= '0;
         o_tlen     <= '0;
      end else begin
         o_valid <= i_valid;
         if (i_valid) begin
            o_count    <= count;
            o_overflow <= overflow;
            for (int s = 0; s < SLOTS; s++) begin
               o_slot_vld[s]                  <= active[s] && !overflow;
               o_head[s*HEAD_W +: HEAD_W]     <= (active[s] && !overflow) ?
                                                 head_raw[s*HEAD_W +: HEAD_W] : '0;
               o_tail[s*TAIL_W +: TAIL_W]     <= overflow ? '0 : tail_raw[s*TAIL_W +: TAIL_W];
               o_tlen[s*LEN_W +: LEN_W]       <= overflow ? '0 : len_act[s*LEN_W +: LEN_W];
            end
         end
      end
   end
endmodule

// File: rtl/htx_bundle_extract_chk.sv
module htx_bundle_extract_chk #(
   parameter int UNIT_W     = 5,
   parameter int N_UNITS    = 25,
   parameter int IDX_W      = 3,
   parameter int HEAD_UNITS = 2,
   parameter int OPC_W      = 5,
   parameter int MAX_TAIL   = 6
) (
   input logic                                     clk,
   input logic                                     rst_n,
   input logic                                     i_valid,
   input logic [IDX_W+UNIT_W*N_UNITS-1:0]          i_bundle,
   input logic                                     o_valid,
   input logic [IDX_W:0]                           o_count,
   input logic                                     o_overflow,
   input logic [(1<<IDX_W)-1:0]                    o_slot_vld,
   input logic [(1<<IDX_W)*HEAD_UNITS*UNIT_W-1:0]  o_head,
   input logic [(1<<IDX_W)*MAX_TAIL*UNIT_W-1:0]    o_tail,
   input logic [(1<<IDX_W)*$clog2(MAX_TAIL+1)-1:0] o_tlen
);
   localparam int SLOTS  = 1 << IDX_W;
   localparam int HEAD_W = HEAD_UNITS * UNIT_W;
   localparam int TAIL_W = MAX_TAIL * UNIT_W;
   localparam int LEN_W  = $clog2(MAX_TAIL + 1);

   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      i_valid |=> o_valid);
   a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> !o_valid);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> $stable(o_count) && $stable(o_head) && $stable(o_tail)
                   && $stable(o_tlen) && $stable(o_slot_vld));
   a_r5_ovf_clears: assert property (@(posedge clk) disable iff (!rst_n)
      o_overflow |-> (o_slot_vld == '0) && (o_head == '0) && (o_tail == '0));
   a_r4_count_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !o_overflow |-> ($countones(o_slot_vld) == int'(o_count)));

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !o_slot_vld[s] |-> (o_head[s*HEAD_W +: HEAD_W] == '0)
                            && (o_tail[s*TAIL_W +: TAIL_W] == '0)
                            && (o_tlen[s*LEN_W +: LEN_W] == '0));
      a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
         o_slot_vld[s] |-> (o_tlen[s*LEN_W +: LEN_W] >= 1)
                           && (int'(o_tlen[s*LEN_W +: LEN_W]) <= MAX_TAIL));
      a_r3_tail_fits: assert property (@(posedge clk) disable iff (!rst_n)
         o_slot_vld[s] |-> ((o_tail[s*TAIL_W +: TAIL_W]
                             >> (UNIT_W * int'(o_tlen[s*LEN_W +: LEN_W]))) == '0));
   end
endmodule

bind htx_bundle_extract htx_bundle_extract_chk #(
   .UNIT_W(UNIT_W), .N_UNITS(N_UNITS), .IDX_W(IDX_W),
   .HEAD_UNITS(HEAD_UNITS), .OPC_W(OPC_W), .MAX_TAIL(MAX_TAIL)
) u_chk (.*);

// File: tb/test_htx_bundle_extract.sv
module test_htx_bundle_extract;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         i_valid = 1'b0;
   logic [127:0] i_bundle = '0;
   logic         o_valid;
   logic [3:0]   o_count;
   logic         o_overflow;
   logic [7:0]   o_slot_vld;
   logic [79:0]  o_head;
   logic [239:0] o_tail;
   logic [23:0]  o_tlen;

   htx_bundle_extract i_htx_bundle_extract (.*);

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state: what the outputs should show now
   bit          e_v = 0;
   int          e_cnt = 0;
   bit          e_ovf = 0;
   bit          e_vld [8];
   logic [9:0]  e_head [8];
   logic [29:0] e_tail [8];
   int          e_len [8];
   string       pend_tag = "R9";

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      string t;
      chk((pend_tag == "") ? "R7" : pend_tag, "o_valid", longint'(o_valid), longint'(e_v));
      chk((pend_tag == "") ? "R1" : pend_tag, "o_count", longint'(o_count), longint'(e_cnt));
      chk((pend_tag == "") ? "R5" : pend_tag, "o_overflow", longint'(o_overflow), longint'(e_ovf));
      for (int s = 0; s < 8; s++) begin
         t = (pend_tag == "") ? "R4" : pend_tag;
         chk(t, $sformatf("slot_vld[%0d]", s), longint'(o_slot_vld[s]), longint'(e_vld[s]));
         t = (pend_tag == "") ? "R1" : pend_tag;
         chk(t, $sformatf("head[%0d]", s), longint'(o_head[s*10 +: 10]), longint'(e_head[s]));
         t = (pend_tag == "") ? "R2" : pend_tag;
         chk(t, $sformatf("tlen[%0d]", s), longint'(o_tlen[s*3 +: 3]), longint'(e_len[s]));
         t = (pend_tag == "") ? "R3" : pend_tag;
         chk(t, $sformatf("tail[%0d]", s), longint'(o_tail[s*30 +: 30]), longint'(e_tail[s]));
      end
   endtask

   // behavioural model of the requirements
   task automatic model(input logic [127:0] b);
      int cnt, sum, op, ln, used;
      cnt = int'(b[127:125]) + 1;
      sum = 0;
      for (int s = 0; s < 8; s++) begin
         e_vld[s] = 0; e_head[s] = '0; e_tail[s] = '0; e_len[s] = 0;
      end
      for (int s = 0; s < cnt; s++) begin
         op = int'(b[124-10*s -: 5]);
         ln = (op % 6) + 1;
         e_vld[s]  = 1;
         e_head[s] = b[124-10*s -: 10];
         e_len[s]  = ln;
         for (int k = 0; k < 5*ln; k++) begin
            if (5*sum + k < 125) e_tail[s][k] = b[5*sum + k];
         end
         sum += ln;
      end
      used = 2*cnt + sum;
      e_cnt = cnt;
      e_ovf = (used > 25);
      if (e_ovf) begin
         for (int s = 0; s < 8; s++) begin
            e_vld[s] = 0; e_head[s] = '0; e_tail[s] = '0; e_len[s] = 0;
         end
      end
   endtask

   // one cycle: check what the previous drive produced, then drive anew
   task automatic cyc(input bit v, input logic [127:0] b, input string tag);
      @(negedge clk);
      compare_all();
      e_v = v;
      if (v) begin
         model(b);
         pend_tag = tag;
      end else begin
         pend_tag = "R8";
      end
      i_valid  = v;
      i_bundle = v ? b : {$urandom, $urandom, $urandom, $urandom};
   endtask

   function automatic logic [127:0] build(input int last, input int ops [8]);
      logic [127:0] b;
      b = {$urandom, $urandom, $urandom, $urandom};
      b[127:125] = 3'(last);
      for (int s = 0; s < 8; s++) b[124-10*s -: 5] = 5'(ops[s]);
      return b;
   endfunction

   initial begin
      int ops [8];
      logic [127:0] b;
      for (int s = 0; s < 8; s++) begin
         e_vld[s] = 0; e_head[s] = '0; e_tail[s] = '0; e_len[s] = 0;
      end
      repeat (3) @(posedge clk);
      // R9: outputs zero while held in reset
      @(negedge clk);
      compare_all();
      rst_n = 1'b1;

      // R6: eight instructions with one-unit tails use 24 units
      ops = '{0, 0, 0, 0, 0, 0, 0, 0};
      cyc(1, build(7, ops), "R6");
      // R6: one tail grown to two units fills exactly 25
      ops = '{0, 0, 0, 1, 0, 0, 0, 0};
      cyc(1, build(7, ops), "R6");
      // R5: three units in that tail need 26
      ops = '{0, 0, 0, 2, 0, 0, 0, 0};
      cyc(1, build(7, ops), "R5");
      // R8: idle cycle keeps the overflow result
      cyc(0, '0, "");
      // R3: single instruction with a six-unit tail
      ops = '{5, 0, 0, 0, 0, 0, 0, 0};
      cyc(1, build(0, ops), "R3");
      // R3: three six-unit tails, 24 units
      ops = '{5, 5, 5, 0, 0, 0, 0, 0};
      cyc(1, build(2, ops), "R3");
      // R5: four six-unit tails, 32 units
      ops = '{5, 5, 5, 5, 0, 0, 0, 0};
      cyc(1, build(3, ops), "R5");
      // R2: upper opcodes wrap (31 -> 2 units, 30 -> 1 unit)
      ops = '{31, 30, 24, 17, 0, 0, 0, 0};
      cyc(1, build(3, ops), "R2");
      // R4: mixed sizes with empty upper slots
      ops = '{1, 3, 2, 4, 9, 9, 9, 9};
      cyc(1, build(3, ops), "R4");
      cyc(0, '0, "");
      cyc(0, '0, "");

      // random bundles with random strobe gaps
      for (int n = 0; n < 3000; n++) begin
         b = {$urandom, $urandom, $urandom, $urandom};
         if (n % 2 == 0) begin
            for (int s = 0; s < 8; s++) b[124-10*s -: 5] = 5'($urandom_range(0, 3) * 6);
         end
         cyc(($urandom_range(0, 3) != 0), b, "");
      end
      cyc(0, '0, "");
      @(negedge clk);
      compare_all();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule